// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block controls entry into and exit from two low-power modes, sleep and suspend, through one 8-bit register on a simple CPU register bus. In a single write, software asks for a mode, picks the events that may end it, and can clear the wake-up flags left by the last wake. While the block is in a low-power mode it watches four event inputs: a port-match pulse, an RTC alarm pulse, an RTC oscillator-failure pulse and a reset-pin glitch pulse. When an armed event arrives, the block records it in a flag, returns to active mode and emits a one-cycle wake pulse.

The first three sources share their register bits. A write to such a bit arms the source, and a read returns the source's flag. An armed source stays armed for one low-power period only, because the block disarms every source when it wakes. While any flag is set, a request to enter a low-power mode is refused. After a wake from suspend, the flags read as zero for a fixed number of clocks (two by default).

The controller is a three-state machine. ACTIVE moves to SLEEP on the enter_sleep transition, which is an accepted write with bit 7 set. ACTIVE moves to SUSPEND on the enter_suspend transition, which is an accepted write with bit 6 set and bit 7 clear. SLEEP and SUSPEND both return to ACTIVE on the wake transition, which is any armed event or a reset-pin glitch.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, the mode output is 00 (active), the read data is 0x00 and the wake pulse is low.
- R2: In active mode, a write with bit 7 set gives mode 10 (sleep) on the next cycle. A write with bit 6 set and bit 7 clear gives mode 01 (suspend). A write with both bits set gives sleep.
- R3: An entry request is refused, and the mode stays 00, while any wake-up flag is set. When the same write also sets bit 5 (clear), the flags are cleared first and the entry succeeds.
- R4: In active mode, a write with bit 5 set clears all flags, read at bits 4..1, to 0.
- R5: In a low-power mode, a pulse on an armed source sets that source's flag. The flag bits are: bit 3 for oscillator failure, bit 2 for alarm and bit 1 for port match. On the next cycle the mode is 00 and the wake pulse is high for exactly one cycle.
- R6: In a low-power mode, pulses on sources that are not armed leave the mode and the flags unchanged.
- R7: Every write in active mode loads the arm bits from write bits 3..1. A wake disarms all sources, so the next entry made without arm bits is not ended by those sources.
- R8: After a wake from suspend, flag bits read 0 for the first two cycles in active mode and show their true value from the third. After a wake from sleep, the flags are visible at once.
- R9: A reset-pin glitch pulse sets flag bit 4 in any mode. In a low-power mode it wakes the block without being armed.
- R10: Read bits 7..5 and bit 0 always read 0.
- R11: Register writes made while in a low-power mode are ignored. They do not change the mode, the arm bits or the flags.
- R12: In active mode, pulses on the port-match, alarm and oscillator-failure inputs set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (flags, masked after a suspend wake) |
| ev_port_match | input | 1 | Port-match event pulse |
| ev_rtc_alarm | input | 1 | RTC alarm event pulse |
| ev_osc_fail | input | 1 | RTC oscillator failure event pulse |
| ev_rst_glitch | input | 1 | Reset-pin glitch event pulse |
| mode | output | 2 | 00 active, 01 suspend, 10 sleep |
| wake_pulse | output | 1 | One-cycle pulse on return to active |

## Verification
Four things are checked by assertions on every cycle: that a wake event in a low-power state leads to ACTIVE with a wake pulse, that a low-power state holds when no wake event arrives, that the arm bits are empty after each wake, and that the unused read bits stay zero. They also check that entry is refused while a flag is pending, and that the flags read zero in the first cycle after a suspend wake. Other behaviour only the directed scenarios can show. This covers the exact cycle on which flags become visible again, the loss of the arm bits across a second entry, the write ignored during sleep, the sleep-over-suspend priority, and the clear-and-enter write. Each of these depends on a sequence of writes and events.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    typedef enum logic [1:0] {
        M_ACTIVE  = 2'b00,
        M_SUSPEND = 2'b01,
        M_SLEEP   = 2'b10
    } lp_mode_e;

    localparam int REG_W    = 8;
    localparam int NSRC     = 3;
    localparam int B_SLEEP  = 7;
    localparam int B_SUSP   = 6;
    localparam int B_CLR    = 5;
    localparam int B_GLITCH = 4;
    localparam int B_SRC_LO = 1;
endpackage

// File: rtl/lpw_flags.sv
module lpw_flags
    import lpw_pkg::*;
#(
    parameter int MASK_CLKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    input  lp_mode_e              mode,
    input  logic                  wake_go,
    input  logic [NSRC-1:0]       ev_src,
    input  logic                  ev_glitch,
    output logic                  ev_hit,
    output logic                  entry_ok,
    output logic [REG_W-1:0]      rd_data
);
    localparam int MW = $clog2(MASK_CLKS + 1);

    logic [NSRC-1:0] en_q, flg_q, flg_nxt, src_set;
    logic            glt_q, glt_nxt;
    logic [MW-1:0]   mask_q;
    logic            active, wr_act, clr;
    logic [NSRC:0]   vis;

    assign active = (mode == M_ACTIVE);
    assign wr_act = wr_en && active;
    assign clr    = wr_act && wr_data[B_CLR];

    always_comb begin
        src_set  = active ? '0 : (ev_src & en_q);
        flg_nxt  = (clr ? '0 : flg_q) | src_set;
        glt_nxt  = (clr ? 1'b0 : glt_q) | ev_glitch;
        entry_ok = (flg_nxt == '0) && !glt_nxt;
        ev_hit   = (|(ev_src & en_q)) || ev_glitch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            flg_q  <= '0;
            glt_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            flg_q <= flg_nxt;
            glt_q <= glt_nxt;
            if (wake_go)
                en_q <= '0;
            else if (wr_act)
                en_q <= wr_data[B_SRC_LO +: NSRC];
            if (wake_go && mode == M_SUSPEND)
                mask_q <= MW'(MASK_CLKS);
            else if (mask_q != '0)
                mask_q <= mask_q - 1'b1;
        end
    end

    always_comb begin
        vis     = (mask_q != '0) ? '0 : {glt_q, flg_q};
        rd_data = '0;
        rd_data[B_SRC_LO +: NSRC+1] = vis;
    end

    // R7: a wake leaves no source armed
    assert_en_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_go |=> (en_q == '0));
    // R8: flags hidden in the first cycle after a suspend wake
    assert_mask_after_susp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_go && mode == M_SUSPEND) |=> (rd_data[B_GLITCH:B_SRC_LO] == '0));
    // R10: unused read bits stay zero
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] == 1'b0) && (rd_data[REG_W-1:B_CLR] == '0));
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
    import lpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             entry_ok,
    input  logic             ev_hit,
    output lp_mode_e         mode,
    output logic             wake_go,
    output logic             wake_pulse
);
    lp_mode_e state_q, state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            M_ACTIVE: begin
                if (wr_en && entry_ok && wr_data[B_SLEEP])
                    state_nxt = M_SLEEP;
                else if (wr_en && entry_ok && wr_data[B_SUSP])
                    state_nxt = M_SUSPEND;
            end
            M_SUSPEND, M_SLEEP: begin
                if (ev_hit)
                    state_nxt = M_ACTIVE;
            end
            default: state_nxt = M_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_ACTIVE;
        else        state_q <= state_nxt;
    end

    assign wake_go = (state_q != M_ACTIVE) && ev_hit;
    assign mode    = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_pulse <= 1'b0;
        else        wake_pulse <= wake_go;
    end

    // R5: an accepted wake event returns to active with a pulse
    assert_wake_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_ACTIVE && ev_hit) |=> (state_q == M_ACTIVE && wake_pulse));
    // R6: no wake event keeps the low-power state
    assert_lp_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_ACTIVE && !ev_hit) |=> $stable(state_q));
    // R3: entry refused while a flag is pending
    assert_entry_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_ACTIVE && !entry_ok) |=> (state_q == M_ACTIVE));
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int MASK_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ev_port_match,
    input  logic       ev_rtc_alarm,
    input  logic       ev_osc_fail,
    input  logic       ev_rst_glitch,
    output logic [1:0] mode,
    output logic       wake_pulse
);
    lp_mode_e        st;
    logic            wake_go, ev_hit, entry_ok;
    logic [NSRC-1:0] ev_src;

    assign ev_src = {ev_osc_fail, ev_rtc_alarm, ev_port_match};

    lpw_flags #(.MASK_CLKS(MASK_CLKS)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode(st), .wake_go(wake_go), .ev_src(ev_src), .ev_glitch(ev_rst_glitch),
        .ev_hit(ev_hit), .entry_ok(entry_ok), .rd_data(rd_data)
    );

    lpw_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .entry_ok(entry_ok), .ev_hit(ev_hit), .mode(st),
        .wake_go(wake_go), .wake_pulse(wake_pulse)
    );

    assign mode = st;
endmodule

// File: tb/sim_lp_wake_ctrl.sv
module sim_lp_wake_ctrl;
    logic       clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic       ev_pm = 0, ev_al = 0, ev_of = 0, ev_gl = 0;
    logic [1:0] mode;
    logic       wake_pulse;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    lp_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_port_match(ev_pm), .ev_rtc_alarm(ev_al), .ev_osc_fail(ev_of),
        .ev_rst_glitch(ev_gl), .mode(mode), .wake_pulse(wake_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = 0;
    endtask

    // e = {glitch, osc, alarm, port match}
    task automatic pulse(input logic [3:0] e);
        @(negedge clk); {ev_gl, ev_of, ev_al, ev_pm} = e;
        @(negedge clk); {ev_gl, ev_of, ev_al, ev_pm} = 4'b0;
    endtask

    task automatic t_reset;
        chk("R1 mode", {6'b0, mode}, 8'h00);
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 wake", {7'b0, wake_pulse}, 8'h00);
    endtask

    task automatic t_sleep_wake;
        wr(8'h20); wr(8'h84);
        chk("R2 sleep entry", {6'b0, mode}, 8'h02);
        pulse(4'b0010);
        chk("R5 mode active", {6'b0, mode}, 8'h00);
        chk("R5 wake pulse", {7'b0, wake_pulse}, 8'h01);
        chk("R8 sleep wake flag visible", rd_data, 8'h04);
        @(negedge clk);
        chk("R5 pulse one cycle", {7'b0, wake_pulse}, 8'h00);
    endtask

    task automatic t_both_bits;
        wr(8'h20); wr(8'hC2);
        chk("R2 both bits sleep", {6'b0, mode}, 8'h02);
        pulse(4'b0001);
        chk("R5 pm flag", rd_data, 8'h02);
    endtask

    task automatic t_blocked_and_mask;
        wr(8'h42);
        chk("R3 entry refused", {6'b0, mode}, 8'h00);
        chk("R3 flag kept", rd_data, 8'h02);
        wr(8'h20);
        chk("R4 clear", rd_data, 8'h00);
        pulse(4'b1000);
        chk("R9 glitch flag active", rd_data, 8'h10);
        wr(8'h68);
        chk("R3 clear plus entry", {6'b0, mode}, 8'h01);
        pulse(4'b0100);
        chk("R8 mode active", {6'b0, mode}, 8'h00);
        chk("R8 masked cycle 1", rd_data, 8'h00);
        @(negedge clk);
        chk("R8 masked cycle 2", rd_data, 8'h00);
        @(negedge clk);
        chk("R8 visible cycle 3", rd_data, 8'h08);
    endtask

    task automatic t_ignored;
        wr(8'h20); wr(8'h84);
        pulse(4'b0101);
        chk("R6 mode held", {6'b0, mode}, 8'h02);
        chk("R6 no pulse", {7'b0, wake_pulse}, 8'h00);
        chk("R6 no flag", rd_data, 8'h00);
        pulse(4'b0010);
        chk("R6 armed wakes", {6'b0, mode}, 8'h00);
    endtask

    task automatic t_rearm;
        wr(8'hA0);
        chk("R7 entry no arm", {6'b0, mode}, 8'h02);
        pulse(4'b0010);
        chk("R7 disarmed stays", {6'b0, mode}, 8'h02);
        pulse(4'b1000);
        chk("R9 glitch wakes", {6'b0, mode}, 8'h00);
        chk("R9 glitch flag", rd_data, 8'h10);
    endtask

    task automatic t_lp_write;
        wr(8'h20); wr(8'h84);
        wr(8'h60);
        chk("R11 mode unchanged", {6'b0, mode}, 8'h02);
        pulse(4'b0010);
        chk("R11 arm kept", rd_data, 8'h04);
        wr(8'hFF);
        chk("R10 reserved zero", rd_data, 8'h00);
        pulse(4'b0001);
        chk("R10 only flag bits", rd_data, 8'h02);
    endtask

    task automatic t_active_events;
        wr(8'h20); wr(8'h0E);
        pulse(4'b0111);
        chk("R12 no flag", rd_data, 8'h00);
        chk("R12 mode", {6'b0, mode}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sleep_wake();
        t_both_bits();
        t_blocked_and_mask();
        t_ignored();
        t_rearm();
        t_lp_write();
        t_active_events();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule